// File: doc/BRIEF.md
# Eight-Input Vectored Interrupt Controller

This block gathers eight level-sensitive request lines into one interrupt line to a processor. A request stays latched until it is acknowledged or cleared by command. Each request can be masked. Priority is fixed: input 0 is the most urgent and input 7 the least. When the processor acknowledges, the controller returns an 8-bit vector taken from a small response memory. It then records the granted request as in service, unless that input has been set up to clear itself automatically.

Software reaches the controller through two byte-wide bus locations, chosen by `bus_sel`:

- **Command/status location (`bus_sel` = 1).** Writes carry opcode-coded commands. These set or clear bits, load the mode byte, and aim a write pointer. Reads return a status byte holding the index of the winning request together with three mode flags.
- **Data location (`bus_sel` = 0).** Writes store into whatever the pointer last selected: the mask, the auto-clear register or one vector slot. Reads return one of the four 8-bit registers, chosen by a mode field.

Top module: `vic8_ctrl`

## Requirements
- R1: A request is pending when its IRR bit is 1 and its IMR bit is 0. The winner is the pending request with the lowest index.
- R2: The data-location read (captured one clock after `bus_sel` is applied) depends on mode bits 6:5. 00 returns ISR, 01 returns IMR, 10 returns IRR and 11 returns ACR.
- R3: The status read has two parts. Bits 2:0 hold the winning index, or the whole byte is 0x80 when nothing is pending. On top of that, mode bit 0 is ORed into bit 5, mode bit 2 into bit 4 and mode bit 7 into bit 3.
- R4: The command 0x00 and the `rst` input both do the same thing. They clear IRR, ISR, ACR, the mode byte and the write pointer, and they set IMR to 0xFF. Vector slots are left untouched.
- R5: Command bits 7:3 choose an operation and bits 2:0 give a bit index. The operations are:
  - 0x10: clear IRR and IMR.
  - 0x18: clear one bit of both IRR and IMR.
  - 0x20: clear IMR.
  - 0x28: clear one IMR bit.
  - 0x30: set IMR to 0xFF.
  - 0x38: set one IMR bit.
  - 0x40: clear IRR.
  - 0x48: clear one IRR bit.
  - 0x50: set IRR to 0xFF.
  - 0x58: set one IRR bit.
- R6: In-service clears work as follows. 0x70 clears ISR. 0x78 clears one ISR bit. 0x60 to 0x6F clear the lowest-index ISR bit that is set.
- R7: 0x80 to 0x9F load mode bits 4:0 from command bits 4:0. 0xA0 to 0xAF copy command bits 3:2 into mode bits 6:5. In that same range, command bits 1:0 = 01 set mode bit 7, 10 clear it, and any other value leaves it unchanged.
- R8: The write pointer is aimed by command. 0xB0 to 0xBF aim it at IMR, 0xC0 to 0xCF at ACR, and 0xE0 to 0xE7 at the vector slot given by bits 2:0. Data-location writes store into the selected target. While the pointer is unaimed (after reset), such writes change nothing.
- R9: `irq_out` is 1 exactly when a request is pending, mode bit 7 (master enable) is 1 and mode bit 2 (polled mode) is 0. It updates on the same clock edge as the state it depends on.
- R10: A one-cycle `int_ack` with a request pending has four effects:
  - `vec_out` takes, on the next edge, slot 0 when mode bit 0 is 1, or otherwise the winner's slot.
  - The winner's IRR bit clears.
  - The winner's ISR bit sets only when its ACR bit is 0.
  - `irq_out` is re-evaluated.
- R11: An `int_ack` with nothing pending drives `vec_out` to 0 and changes no register.
- R12: Each clock, a high level on any `irq_in` bit sets that IRR bit. In the same cycle this overrides a clearing command.
- R13: Opcodes not listed are ignored. This covers 0x01 to 0x0F, 0xD0 to 0xDF and 0xE8 to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | 1 = command/status location, 0 = data location |
| bus_wr | input | 1 | Write strobe for the selected location |
| bus_wdata | input | 8 | Write data or command byte |
| bus_rdata | output | 8 | Registered read data of the location selected on the previous cycle |
| irq_in | input | 8 | Level request inputs |
| irq_out | output | 1 | Registered interrupt line to the processor |
| int_ack | input | 1 | One-cycle acknowledge strobe |
| vec_out | output | 8 | Vector returned for the last acknowledge |

## Verification
The hardest states to reach from the ports are those where several sources change IRR in the same clock. One case is a request input arriving while a clearing command is being written. Another is an acknowledge being granted while other requests remain pending. The directed tasks drive the request lines and the command write on the same negative edge, so both land on one rising edge. They also stack two requests before issuing back-to-back acknowledges. Auto-clear, common-vector selection and the empty acknowledge are each reached by programming ACR, the mode byte and the vector slots through the pointer sequence before a request is raised.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NIRQ  = 8;
  localparam int DW    = 8;
  localparam int IDX_W = $clog2(NIRQ);

  localparam int MODE_VS = 0;  // common-vector select
  localparam int MODE_IM = 2;  // polled mode, blocks irq_out
  localparam int MODE_MM = 7;  // master enable

  typedef enum logic [1:0] {
    PTR_NONE,
    PTR_MASK,
    PTR_AUTO,
    PTR_SLOT
  } wptr_e;

  typedef enum logic [4:0] {
    OP_NOP,
    OP_RESET,
    OP_CLR_RQ_MSK,
    OP_CLR_RQ_MSK_BIT,
    OP_CLR_MSK,
    OP_CLR_MSK_BIT,
    OP_SET_MSK,
    OP_SET_MSK_BIT,
    OP_CLR_RQ,
    OP_CLR_RQ_BIT,
    OP_SET_RQ,
    OP_SET_RQ_BIT,
    OP_CLR_SRV_TOP,
    OP_CLR_SRV,
    OP_CLR_SRV_BIT,
    OP_MODE_LO,
    OP_MODE_HI,
    OP_PTR_MASK,
    OP_PTR_AUTO,
    OP_PTR_SLOT
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [IDX_W-1:0] idx;
    logic [4:0]       mode_lo;
    logic [1:0]       rd_sel;
    logic [1:0]       mm_ctl;
  } cmd_t;
endpackage

// File: rtl/vic_cmd_dec.sv
module vic_cmd_dec
  import vic_pkg::*;
(
  input  logic [7:0] byte_i,
  output cmd_t       cmd_o
);
  always_comb begin
    cmd_o.idx     = byte_i[IDX_W-1:0];
    cmd_o.mode_lo = byte_i[4:0];
    cmd_o.rd_sel  = byte_i[3:2];
    cmd_o.mm_ctl  = byte_i[1:0];
    casez (byte_i[7:3])
      5'b00000: cmd_o.op = (byte_i[2:0] == 3'd0) ? OP_RESET : OP_NOP;
      5'b00010: cmd_o.op = OP_CLR_RQ_MSK;
      5'b00011: cmd_o.op = OP_CLR_RQ_MSK_BIT;
      5'b00100: cmd_o.op = OP_CLR_MSK;
      5'b00101: cmd_o.op = OP_CLR_MSK_BIT;
      5'b00110: cmd_o.op = OP_SET_MSK;
      5'b00111: cmd_o.op = OP_SET_MSK_BIT;
      5'b01000: cmd_o.op = OP_CLR_RQ;
      5'b01001: cmd_o.op = OP_CLR_RQ_BIT;
      5'b01010: cmd_o.op = OP_SET_RQ;
      5'b01011: cmd_o.op = OP_SET_RQ_BIT;
      5'b0110?: cmd_o.op = OP_CLR_SRV_TOP;
      5'b01110: cmd_o.op = OP_CLR_SRV;
      5'b01111: cmd_o.op = OP_CLR_SRV_BIT;
      5'b100??: cmd_o.op = OP_MODE_LO;
      5'b1010?: cmd_o.op = OP_MODE_HI;
      5'b1011?: cmd_o.op = OP_PTR_MASK;
      5'b1100?: cmd_o.op = OP_PTR_AUTO;
      5'b11100: cmd_o.op = OP_PTR_SLOT;
      default:  cmd_o.op = OP_NOP;
    endcase
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

  logic [N-1:0] below;
  always_comb begin
    below = (N'(1) << idx_o) - N'(1);
    if (found_o) begin
      // R1
      prio_chk: assert (req_i[idx_o] && ((req_i & below) == '0))
        else $error("winner is not the lowest set index");
    end
  end
endmodule

// File: rtl/vic_vec_ram.sv
module vic_vec_ram #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/vic8_ctrl.sv
module vic8_ctrl
  import vic_pkg::*;
#(
  parameter int NI = vic_pkg::NIRQ,
  parameter int BW = vic_pkg::DW,
  localparam int IW = $clog2(NI)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  input  logic [NI-1:0] irq_in,
  output logic          irq_out,
  input  logic          int_ack,
  output logic [BW-1:0] vec_out
);
  logic [NI-1:0] irr_q, isr_q, imr_q, acr_q;
  logic [NI-1:0] irr_n, isr_n, imr_n, acr_n;
  logic [7:0]    mode_q, mode_n;
  wptr_e         wptr_q, wptr_n;
  logic [IW-1:0] slot_q, slot_n;
  logic          none_q;
  logic [BW-1:0] ram_q;

  logic          cmd_wr, dat_wr, ack_take;
  cmd_t          cmd;
  logic [NI-1:0] pend, one_bit;
  logic          pend_found, srv_found;
  logic [IW-1:0] pend_idx, srv_idx;
  logic [BW-1:0] stat_w, rdbk_w;

  assign cmd_wr = bus_wr & bus_sel;
  assign dat_wr = bus_wr & ~bus_sel;
  assign pend   = irr_q & ~imr_q;

  vic_cmd_dec u_dec (.byte_i(bus_wdata[7:0]), .cmd_o(cmd));

  vic_prio #(.N(NI)) u_pend (.req_i(pend),  .found_o(pend_found), .idx_o(pend_idx));
  vic_prio #(.N(NI)) u_srv  (.req_i(isr_q), .found_o(srv_found),  .idx_o(srv_idx));

  assign ack_take = int_ack & pend_found;
  assign one_bit  = NI'(1) << cmd.idx;

  always_comb begin
    irr_n  = irr_q;
    isr_n  = isr_q;
    imr_n  = imr_q;
    acr_n  = acr_q;
    mode_n = mode_q;
    wptr_n = wptr_q;
    slot_n = slot_q;
    if (cmd_wr) begin
      unique case (cmd.op)
        OP_RESET: begin
          irr_n  = '0;
          isr_n  = '0;
          imr_n  = '1;
          acr_n  = '0;
          mode_n = '0;
          wptr_n = PTR_NONE;
        end
        OP_CLR_RQ_MSK:     begin irr_n = '0; imr_n = '0; end
        OP_CLR_RQ_MSK_BIT: begin irr_n = irr_q & ~one_bit; imr_n = imr_q & ~one_bit; end
        OP_CLR_MSK:        imr_n = '0;
        OP_CLR_MSK_BIT:    imr_n = imr_q & ~one_bit;
        OP_SET_MSK:        imr_n = '1;
        OP_SET_MSK_BIT:    imr_n = imr_q | one_bit;
        OP_CLR_RQ:         irr_n = '0;
        OP_CLR_RQ_BIT:     irr_n = irr_q & ~one_bit;
        OP_SET_RQ:         irr_n = '1;
        OP_SET_RQ_BIT:     irr_n = irr_q | one_bit;
        OP_CLR_SRV_TOP:    if (srv_found) isr_n[srv_idx] = 1'b0;
        OP_CLR_SRV:        isr_n = '0;
        OP_CLR_SRV_BIT:    isr_n = isr_q & ~one_bit;
        OP_MODE_LO:        mode_n[4:0] = cmd.mode_lo;
        OP_MODE_HI: begin
          mode_n[6:5] = cmd.rd_sel;
          if (cmd.mm_ctl == 2'b01)      mode_n[MODE_MM] = 1'b1;
          else if (cmd.mm_ctl == 2'b10) mode_n[MODE_MM] = 1'b0;
        end
        OP_PTR_MASK: wptr_n = PTR_MASK;
        OP_PTR_AUTO: wptr_n = PTR_AUTO;
        OP_PTR_SLOT: begin wptr_n = PTR_SLOT; slot_n = cmd.idx; end
        default: ;
      endcase
    end
    if (dat_wr) begin
      if (wptr_q == PTR_MASK) imr_n = bus_wdata[NI-1:0];
      if (wptr_q == PTR_AUTO) acr_n = bus_wdata[NI-1:0];
    end
    if (ack_take) begin
      irr_n[pend_idx] = 1'b0;
      if (!acr_q[pend_idx]) isr_n[pend_idx] = 1'b1;
    end
    irr_n = irr_n | irq_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q   <= '0;
      isr_q   <= '0;
      imr_q   <= '1;
      acr_q   <= '0;
      mode_q  <= '0;
      wptr_q  <= PTR_NONE;
      slot_q  <= '0;
      irq_out <= 1'b0;
    end else begin
      irr_q   <= irr_n;
      isr_q   <= isr_n;
      imr_q   <= imr_n;
      acr_q   <= acr_n;
      mode_q  <= mode_n;
      wptr_q  <= wptr_n;
      slot_q  <= slot_n;
      irq_out <= (|(irr_n & ~imr_n)) & mode_n[MODE_MM] & ~mode_n[MODE_IM];
    end
  end

  // Readback and status
  always_comb begin
    stat_w    = pend_found ? BW'(pend_idx) : BW'(8'h80);
    stat_w[5] = stat_w[5] | mode_q[MODE_VS];
    stat_w[4] = stat_w[4] | mode_q[MODE_IM];
    stat_w[3] = stat_w[3] | mode_q[MODE_MM];
    unique case (mode_q[6:5])
      2'b00:   rdbk_w = BW'(isr_q);
      2'b01:   rdbk_w = BW'(imr_q);
      2'b10:   rdbk_w = BW'(irr_q);
      default: rdbk_w = BW'(acr_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_sel ? stat_w : rdbk_w;
  end

  // Vector response memory
  vic_vec_ram #(.DEPTH(NI), .W(BW)) u_vec (
    .clk  (clk),
    .we   (dat_wr && (wptr_q == PTR_SLOT)),
    .waddr(slot_q),
    .wdata(bus_wdata),
    .re   (int_ack),
    .raddr(mode_q[MODE_VS] ? IW'(0) : pend_idx),
    .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst)          none_q <= 1'b1;
    else if (int_ack) none_q <= ~pend_found;
  end

  assign vec_out = none_q ? '0 : ram_q;

  // R4
  reset_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && bus_wdata == '0 && !int_ack) |=> (imr_q == '1 && isr_q == '0 && mode_q == '0 && acr_q == '0));

  // R8
  nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (dat_wr && wptr_q == PTR_NONE) |=> ($stable(imr_q) && $stable(acr_q)));

  // R10
  ack_isr_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_take && !acr_q[pend_idx] && !cmd_wr) |=> isr_q[$past(pend_idx)]);

  // R10
  ack_irr_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_take && !irq_in[pend_idx] && !cmd_wr) |=> !irr_q[$past(pend_idx)]);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (mode_q[MODE_MM] && !mode_q[MODE_IM] && (|(irr_q & ~imr_q))));
endmodule

// File: tb/vic8_ctrl_tb.sv
module vic8_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] irq_in = '0;
  logic       irq_out;
  logic       int_ack = 1'b0;
  logic [7:0] vec_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vic8_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .irq_out(irq_out), .int_ack(int_ack), .vec_out(vec_out)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic cmd(input logic [7:0] d);
    wr(1'b1, d);
  endtask

  task automatic rd(input logic s, output logic [7:0] v);
    @(negedge clk);
    bus_sel = s;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic pulse(input logic [7:0] b);
    @(negedge clk);
    irq_in = b;
    @(negedge clk);
    irq_in = '0;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk);
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
    v = vec_out;
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    chk("R9 irq low after reset", {7'd0, irq_out}, 8'h00);
    rd(1'b0, v); chk("R4 ISR after reset", v, 8'h00);
    rd(1'b1, v); chk("R3 status idle", v, 8'h80);
    cmd(8'hA4);
    rd(1'b0, v); chk("R4 IMR after reset", v, 8'hFF);
    chk("R11 vec after reset", vec_out, 8'h00);
  endtask

  task automatic t_bit_cmds();
    logic [7:0] v;
    cmd(8'h00); cmd(8'hA4);
    cmd(8'h20); rd(1'b0, v); chk("R5 clear IMR", v, 8'h00);
    cmd(8'h3B); rd(1'b0, v); chk("R5 set IMR bit3", v, 8'h08);
    cmd(8'h30); rd(1'b0, v); chk("R5 set IMR", v, 8'hFF);
    cmd(8'h2D); rd(1'b0, v); chk("R5 clear IMR bit5", v, 8'hDF);
    cmd(8'hA8);
    cmd(8'h5E); rd(1'b0, v); chk("R2 R5 IRR bit6", v, 8'h40);
    cmd(8'h50); rd(1'b0, v); chk("R5 set IRR", v, 8'hFF);
    cmd(8'h49); rd(1'b0, v); chk("R5 clear IRR bit1", v, 8'hFD);
    cmd(8'h40); rd(1'b0, v); chk("R5 clear IRR", v, 8'h00);
    cmd(8'h50); cmd(8'h30); cmd(8'h1A);
    rd(1'b0, v); chk("R5 combo bit IRR", v, 8'hFB);
    cmd(8'hA4); rd(1'b0, v); chk("R5 combo bit IMR", v, 8'hFB);
    cmd(8'h10); rd(1'b0, v); chk("R5 combo clear IMR", v, 8'h00);
    cmd(8'hA8); rd(1'b0, v); chk("R5 combo clear IRR", v, 8'h00);
  endtask

  task automatic t_status_irq();
    logic [7:0] v;
    cmd(8'h00); cmd(8'h20);
    pulse(8'hA0);
    chk("R9 no master enable", {7'd0, irq_out}, 8'h00);
    rd(1'b1, v); chk("R1 R3 status idx5", v, 8'h05);
    cmd(8'hA1);
    chk("R7 R9 master enable", {7'd0, irq_out}, 8'h01);
    rd(1'b1, v); chk("R3 status with mode7", v, 8'h0D);
    cmd(8'h3D);
    rd(1'b1, v); chk("R1 masked winner skipped", v, 8'h0F);
    cmd(8'h84);
    chk("R9 polled blocks irq", {7'd0, irq_out}, 8'h00);
    rd(1'b1, v); chk("R3 R7 status polled", v, 8'h1F);
    cmd(8'h81);
    chk("R9 irq back", {7'd0, irq_out}, 8'h01);
    rd(1'b1, v); chk("R3 status vs bit", v, 8'h2F);
    cmd(8'hA2);
    chk("R7 clear master enable", {7'd0, irq_out}, 8'h00);
  endtask

  task automatic t_ack();
    logic [7:0] v;
    cmd(8'h00);
    for (int i = 0; i < 8; i++) begin
      cmd(8'hE0 | 8'(i));
      wr(1'b0, 8'h40 + 8'(4 * i));
    end
    cmd(8'h80); cmd(8'hA1); cmd(8'h20);
    pulse(8'h12);
    ack(v); chk("R10 vector slot1", v, 8'h44);
    chk("R10 irq stays for bit4", {7'd0, irq_out}, 8'h01);
    rd(1'b0, v); chk("R10 ISR bit1 set", v, 8'h02);
    ack(v); chk("R10 vector slot4", v, 8'h50);
    chk("R10 irq drops", {7'd0, irq_out}, 8'h00);
    rd(1'b0, v); chk("R10 ISR bits1,4", v, 8'h12);
    ack(v); chk("R11 empty ack vector", v, 8'h00);
    rd(1'b0, v); chk("R11 ISR unchanged", v, 8'h12);
    cmd(8'hA9); rd(1'b0, v); chk("R10 IRR cleared", v, 8'h00);
    cmd(8'hA1);
    cmd(8'h60); rd(1'b0, v); chk("R6 clear top ISR", v, 8'h10);
    cmd(8'h7C); rd(1'b0, v); chk("R6 clear ISR bit4", v, 8'h00);
    pulse(8'h01); ack(v); chk("R10 vector slot0", v, 8'h40);
    cmd(8'h70); rd(1'b0, v); chk("R6 clear ISR", v, 8'h00);
  endtask

  task automatic t_autoclear_vs();
    logic [7:0] v;
    cmd(8'hC0); wr(1'b0, 8'h08);
    cmd(8'hAC); rd(1'b0, v); chk("R8 ACR written", v, 8'h08);
    pulse(8'h08);
    ack(v); chk("R10 vector slot3", v, 8'h4C);
    cmd(8'hA0); rd(1'b0, v); chk("R10 auto-clear skips ISR", v, 8'h00);
    chk("R10 irq low after ack", {7'd0, irq_out}, 8'h00);
    cmd(8'h81);
    pulse(8'h40);
    ack(v); chk("R10 common vector", v, 8'h40);
    rd(1'b0, v); chk("R10 ISR bit6", v, 8'h40);
    cmd(8'hB0); wr(1'b0, 8'hF0);
    cmd(8'hA4); rd(1'b0, v); chk("R8 IMR via pointer", v, 8'hF0);
  endtask

  task automatic t_ignored();
    logic [7:0] v;
    cmd(8'h00);
    wr(1'b0, 8'h55);
    cmd(8'hA4); rd(1'b0, v); chk("R8 unaimed write IMR", v, 8'hFF);
    cmd(8'hAC); rd(1'b0, v); chk("R8 unaimed write ACR", v, 8'h00);
    cmd(8'h5A);
    cmd(8'hD3); cmd(8'h08); cmd(8'h05); cmd(8'hE9);
    wr(1'b0, 8'h33);
    rd(1'b0, v); chk("R13 ACR kept", v, 8'h00);
    cmd(8'hA4); rd(1'b0, v); chk("R13 IMR kept", v, 8'hFF);
    cmd(8'hA8); rd(1'b0, v); chk("R13 IRR kept", v, 8'h04);
    rd(1'b1, v); chk("R13 status kept", v, 8'h80);
  endtask

  task automatic t_request_wins();
    logic [7:0] v;
    cmd(8'h50);
    @(negedge clk);
    irq_in = 8'h04; bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h40;
    @(negedge clk);
    irq_in = '0; bus_wr = 1'b0; bus_wdata = '0;
    rd(1'b0, v); chk("R12 request beats clear", v, 8'h04);
    pulse(8'h81);
    rd(1'b0, v); chk("R12 request sets IRR", v, 8'h85);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_bit_cmds();
    t_status_irq();
    t_ack();
    t_autoclear_vs();
    t_ignored();
    t_request_wins();
    done = 1;
  end

  initial begin
    while (!done && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule